// File: doc/BRIEF.md
# Serial Display Command and Data Transmitter

This block shifts bytes out to a display controller over four wires: an active-low chip select, a select line that marks a byte as an instruction or as pixel/parameter data, a serial clock and a serial data line. A host hands bytes over one at a time on a valid/ready interface. The first byte of a transfer carries a flag that says whether the transfer is one instruction byte or a data burst. A burst runs until the host marks a byte as last, and the whole burst stays under a single chip-select assertion.

Each bit stays on the data line for one programmable half-period with the clock low, then for one half-period with the clock high. The half-period is `HALF_CLKS` system clocks. When a transfer starts, the clock is low and the data line is high for one half-period before the first bit. When the transfer ends, all four lines go high together. In that same cycle a one-cycle `done` pulse is raised and `busy` drops.

Top module: `lcd_serial_tx`

## Requirements
- R1: In reset and in idle, `lcd_cs_n`, `lcd_dc`, `lcd_sclk` and `lcd_sdo` are all 1, `busy` and `done` are 0, and `in_ready` is 1.
- R2: `lcd_cs_n` falls once when a request is accepted and stays 0 until the last bit of the transfer has been clocked. It then rises exactly once.
- R3: `lcd_dc` is 0 for a transfer started with `in_is_data`=0 (an instruction) and 1 for one started with `in_is_data`=1 (data). It holds that value for the whole time `lcd_cs_n` is 0, including at the eighth rising clock edge of every byte.
- R4: Each byte produces exactly eight rising edges of `lcd_sclk`, with bit 7 first and bit 0 last. `lcd_sdo` never changes at a rising edge or while `lcd_sclk` is 1.
- R5: In the cycle where `lcd_cs_n` first reads 0, `lcd_sclk` is 0 and `lcd_sdo` is 1. This preset level lasts one half-period before the first bit is driven.
- R6: Every high phase of `lcd_sclk` inside a transfer lasts exactly `HALF_CLKS` cycles. An instruction keeps `lcd_cs_n` low for exactly 17×`HALF_CLKS` cycles.
- R7: An instruction transfer sends exactly one byte, whatever the value of `in_last`.
- R8: A data transfer sends the accepted bytes back to back under one chip select, ending after the byte with `in_last`=1. The `in_is_data` value on the second and later bytes is ignored. Between bytes the block waits with `lcd_cs_n`=0 and `lcd_sclk`=0 for as long as the host needs.
- R9: `in_ready` is 0 during the preset and bit phases, and 1 only when idle or when waiting for the next byte of a burst.
- R10: `done` is a one-cycle pulse. It is raised in the first cycle in which all four lines are back at 1 and `busy` is 0.
- R11: With the synchronous active-low reset asserted at a clock edge, the lines return to the idle levels of R1 after that edge, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block takes the byte at this edge if `in_valid` is 1 |
| in_data | input | BYTE_W | Byte to send, MSB first |
| in_is_data | input | 1 | On the first byte: 1 = data burst, 0 = one instruction byte |
| in_last | input | 1 | Marks the final byte of a data burst |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the idle levels are restored |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_dc | output | 1 | 0 = instruction, 1 = data |
| lcd_sclk | output | 1 | Serial clock, rests low inside a transfer |
| lcd_sdo | output | 1 | Serial data, sampled by the display on rising `lcd_sclk` |

## Verification
The bench sends all 256 instruction byte values, with the last flag toggled, and data bursts of one to six bytes, both back to back and with long host stalls. A decoder in the bench rebuilds every byte from the pins. A block that shifted LSB first, or that missed or added a clock pulse, would rebuild the wrong bytes. One that dropped chip select between burst bytes, or followed a stray last flag on an instruction, would show extra chip-select edges or the wrong byte count. The bench also measures the high-phase width and the chip-select width of an instruction to catch an off-by-one in the divider, checks the preset-high data level at chip-select fall, checks that `done` is one cycle wide and coincides with the idle levels, and asserts reset in the middle of a burst.

// File: rtl/lcd_tx_pkg.sv
// Shared types of the serial display transmitter.
// Assumes: nothing; the package holds only the sequencer state encoding.
package lcd_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // all lines high, waiting for a request
        ST_PRE,    // select low, clock low, data preset high
        ST_LOW,    // bit on data line, clock low
        ST_HIGH,   // clock high, display samples the bit
        ST_WAIT    // burst paused between bytes, clock low
    } tx_state_t;

endpackage

// File: rtl/lcd_tx_divider.sv
// Half-period timer for the serial clock.
// Raises tick in the last cycle of every half-period of HALF_CLKS system clocks.
// Assumes: HALF_CLKS >= 1; restart holds the count at zero so the next phase is full length.
module lcd_tx_divider #(
    parameter int HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(HALF_CLKS - 1));

    // Count system clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the phase counter never passes the half-period length.
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < HALF_CLKS);

endmodule

// File: rtl/lcd_tx_shifter.sv
// MSB-first byte shifter with bit counter.
// Load takes a new byte and clears the count. Shift moves the next bit to the top.
// Assumes: load and shift are never raised together.
module lcd_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    output logic         msb,
    output logic         last_bit
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sreg;
    logic [BW-1:0] bcnt;

    assign msb      = sreg[W-1];
    assign last_bit = (bcnt == BW'(W - 1));

    // Hold the byte being sent and count the bits already clocked out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            bcnt <= '0;
        end else if (load) begin
            sreg <= load_data;
            bcnt <= '0;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
            bcnt <= last_bit ? '0 : bcnt + 1'b1;
        end
    end

    // R4: a byte is never reloaded while it is still being shifted.
    a_r4_no_load_and_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/lcd_serial_tx.sv
// Serial display transmitter: sequences chip select, instruction/data select,
// serial clock and serial data for one instruction byte or a data burst.
// Assumes: the host holds in_* stable while in_valid=1 and in_ready=0.
// Output lines are decoded from registered state and stay stable within each phase.
module lcd_serial_tx
    import lcd_tx_pkg::*;
#(
    parameter int HALF_CLKS = 2,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_is_data,
    input  logic              in_last,
    output logic              busy,
    output logic              done,
    output logic              lcd_cs_n,
    output logic              lcd_dc,
    output logic              lcd_sclk,
    output logic              lcd_sdo
);
    tx_state_t state;
    logic      mode_q;
    logic      last_q;
    logic      done_q;
    logic      tick;
    logic      bit_msb;
    logic      bit_last;
    logic      accept;
    logic      shift;

    assign in_ready = (state == ST_IDLE) || (state == ST_WAIT);
    assign accept   = in_valid && in_ready;
    assign shift    = (state == ST_HIGH) && tick;
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;

    lcd_tx_divider #(.HALF_CLKS(HALF_CLKS)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (in_ready),
        .tick    (tick)
    );

    lcd_tx_shifter #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (in_data),
        .shift     (shift),
        .msb       (bit_msb),
        .last_bit  (bit_last)
    );

    // Step through preset, bit and wait phases; latch the mode and the end of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= 1'b1;
            last_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    mode_q <= in_is_data;
                    last_q <= !in_is_data || in_last;
                    state  <= ST_PRE;
                end
                ST_PRE:  if (tick) state <= ST_LOW;
                ST_LOW:  if (tick) state <= ST_HIGH;
                ST_HIGH: if (tick) begin
                    if (!bit_last) begin
                        state <= ST_LOW;
                    end else if (last_q) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: if (accept) begin
                    last_q <= in_last;
                    state  <= ST_LOW;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the four line levels from the current phase.
    always_comb begin
        lcd_cs_n = 1'b0;
        lcd_dc   = mode_q;
        lcd_sclk = 1'b0;
        lcd_sdo  = bit_msb;
        unique case (state)
            ST_IDLE: begin
                lcd_cs_n = 1'b1;
                lcd_dc   = 1'b1;
                lcd_sclk = 1'b1;
                lcd_sdo  = 1'b1;
            end
            ST_PRE:  lcd_sdo  = 1'b1;
            ST_HIGH: lcd_sclk = 1'b1;
            default: ;
        endcase
    end

    // R1: whenever select is released, every other line is at its idle level.
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs_n |-> (lcd_dc && lcd_sclk && lcd_sdo && !busy));

    // R3: the instruction/data line does not move during a transfer.
    a_r3_dc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_dc));

    // R4: data is steady at each rising clock edge inside a transfer.
    a_r4_sdo_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_sclk) && !lcd_cs_n) |-> $stable(lcd_sdo));

    // R4: data does not change while the clock stays high.
    a_r4_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_sclk && $past(lcd_sclk) && !lcd_cs_n) |-> $stable(lcd_sdo));

    // R9: no byte is taken while a bit is on the line with the clock high.
    a_r9_no_ready_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && lcd_sclk) |-> !in_ready);

    // R10: done is one cycle wide and coincides with the idle levels.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lcd_cs_n && lcd_sclk && !busy));

endmodule

// File: tb/lcd_serial_tx_test.sv
module lcd_serial_tx_test;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_is_data = 1'b0;
    logic       in_last = 1'b0;
    logic       busy, done;
    logic       lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdo;

    int checks = 0;
    int errors = 0;

    // Bench-side decoder state.
    logic [7:0] rx_b [0:15];
    logic       rx_d [0:15];
    int         rx_n = 0;
    logic [7:0] shreg = 8'h00;
    int         bitn = 0;
    int         cs_falls = 0;
    int         cs_rises = 0;
    int         hi_run = 0;
    int         cs_low_run = 0;
    int         last_cs_low = 0;
    logic       prev_sclk = 1'b1;
    logic       prev_cs = 1'b1;
    logic       prev_sdo = 1'b1;
    logic       done_prev = 1'b0;

    logic [7:0] exp_b [0:15];

    always #5 clk = ~clk;

    lcd_serial_tx #(.HALF_CLKS(HALF), .BYTE_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_is_data (in_is_data),
        .in_last    (in_last),
        .busy       (busy),
        .done       (done),
        .lcd_cs_n   (lcd_cs_n),
        .lcd_dc     (lcd_dc),
        .lcd_sclk   (lcd_sclk),
        .lcd_sdo    (lcd_sdo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Decoder: rebuild bytes and timing from the pins, sampled at falling clk.
    always @(negedge clk) begin
        if (!rst_n) begin
            bitn = 0;
            hi_run = 0;
            cs_low_run = 0;
            prev_sclk = lcd_sclk;
            prev_cs = lcd_cs_n;
            prev_sdo = lcd_sdo;
            done_prev = 1'b0;
        end else begin
            if (prev_cs && !lcd_cs_n) begin
                cs_falls++;
                bitn = 0;
                cs_low_run = 0;
                chk(lcd_sdo && !lcd_sclk, "R5 preset at select fall", {lcd_sclk, lcd_sdo}, 1);
            end
            if (!lcd_cs_n) cs_low_run++;
            if (!lcd_cs_n && lcd_sclk && !prev_sclk) begin
                chk(!in_ready, "R9 ready low in bit", in_ready, 0);
                shreg = {shreg[6:0], lcd_sdo};
                bitn++;
                if (bitn == 8) begin
                    if (rx_n < 16) begin
                        rx_b[rx_n] = shreg;
                        rx_d[rx_n] = lcd_dc;
                    end
                    rx_n++;
                    bitn = 0;
                end
            end
            if (!lcd_cs_n && lcd_sclk && prev_sclk && (lcd_sdo != prev_sdo)) begin
                chk(1'b0, "R4 data moved with clock high", lcd_sdo, prev_sdo);
            end
            if (!lcd_cs_n && lcd_sclk) begin
                hi_run++;
            end else if (hi_run != 0) begin
                chk(hi_run == HALF, "R6 clock high width", hi_run, HALF);
                hi_run = 0;
            end
            if (!prev_cs && lcd_cs_n) begin
                cs_rises++;
                last_cs_low = cs_low_run;
                chk(lcd_dc && lcd_sclk && lcd_sdo, "R2 lines high at end",
                    {lcd_dc, lcd_sclk, lcd_sdo}, 7);
                chk(bitn == 0, "R4 whole bytes only", bitn, 0);
            end
            if (done) begin
                chk(lcd_cs_n && lcd_dc && lcd_sclk && lcd_sdo && !busy, "R10 done with idle",
                    {lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdo, busy}, 30);
                chk(!done_prev, "R10 done width", done_prev, 0);
            end
            done_prev = done;
            prev_sclk = lcd_sclk;
            prev_cs = lcd_cs_n;
            prev_sdo = lcd_sdo;
        end
    end

    // Offer one byte; returns at the falling edge after it was taken.
    task automatic put(input logic [7:0] b, input logic isd, input logic last);
        in_valid = 1'b1;
        in_data = b;
        in_is_data = isd;
        in_last = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 8'h00;
        in_last = 1'b0;
    endtask

    task automatic wait_done;
        int t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R10 done seen", done, 1);
        @(negedge clk);
    endtask

    task automatic clear_rx;
        rx_n = 0;
        cs_falls = 0;
        cs_rises = 0;
    endtask

    // Compare the decoded bytes of one transfer against the expectation.
    task automatic verify(input int n, input logic dc_exp, input string tag);
        chk(rx_n == n, {tag, " byte count"}, rx_n, n);
        chk(cs_falls == 1 && cs_rises == 1, "R2 one select window", cs_falls * 10 + cs_rises, 11);
        for (int i = 0; i < n && i < rx_n && i < 16; i++) begin
            chk(rx_b[i] == exp_b[i], {tag, " byte value"}, rx_b[i], exp_b[i]);
            chk(rx_d[i] == dc_exp, "R3 select at eighth edge", rx_d[i], dc_exp);
        end
        clear_rx();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(lcd_cs_n && lcd_dc && lcd_sclk && lcd_sdo, "R1 idle lines in reset",
            {lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdo}, 15);
        chk(!busy && !done && in_ready, "R1 idle flags in reset", {busy, done, in_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lcd_cs_n && lcd_sclk && in_ready && !busy, "R1 idle after release",
            {lcd_cs_n, lcd_sclk, in_ready, busy}, 14);
        clear_rx();

        // R7: every instruction value, last flag toggled and ignored.
        for (int v = 0; v < 256; v++) begin
            exp_b[0] = v[7:0];
            put(v[7:0], 1'b0, v[0]);
            wait_done();
            chk(last_cs_low == 17 * HALF, "R6 instruction select width", last_cs_low, 17 * HALF);
            verify(1, 1'b0, "R7 instruction");
        end

        // R8: data bursts, back to back and with long host stalls.
        for (int stall = 0; stall < 2; stall++) begin
            for (int len = 1; len <= 6; len++) begin
                for (int i = 0; i < len; i++) begin
                    exp_b[i] = 8'((len * 29 + i * 71 + stall * 5) & 255);
                    if (stall != 0 && i != 0) begin
                        repeat (40) @(negedge clk);
                        chk(in_ready && !lcd_cs_n && !lcd_sclk, "R8 waiting between bytes",
                            {in_ready, lcd_cs_n, lcd_sclk}, 4);
                    end
                    put(exp_b[i], (i == 0) ? 1'b1 : i[0], i == len - 1);
                end
                wait_done();
                verify(len, 1'b1, "R8 burst");
            end
        end

        // R11: reset in the middle of a burst.
        put(8'hA5, 1'b1, 1'b0);
        repeat (7) @(negedge clk);
        chk(!lcd_cs_n && busy, "R11 transfer running", {lcd_cs_n, busy}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(lcd_cs_n && lcd_dc && lcd_sclk && lcd_sdo && !busy, "R11 idle after reset",
            {lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdo, busy}, 30);
        rst_n = 1'b1;
        @(negedge clk);
        clear_rx();
        exp_b[0] = 8'h3C;
        put(8'h3C, 1'b0, 1'b0);
        wait_done();
        verify(1, 1'b0, "R11 recovery");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule